// File: doc/BRIEF.md
# Mixed-Resolution Pulse-Width Modulator

This block drives eight pulse-width outputs from a single free-running 8-bit base counter. Six of the outputs have 8-bit resolution. Two have 14-bit resolution. Each base period is 256 clocks long. At the end of every period the base counter wraps, and that wrap raises every enabled output whose programmed duty is not zero. An 8-bit output then falls when the counter reaches that output's compare value.

The two fine-resolution outputs take their upper eight compare bits as the base duty. Their six lower bits choose how many of the 64 base periods in a frame carry one extra high clock. The stretched periods are spread evenly across the frame. A frame counter advances once per base period. The fine compare values are copied into a shadow register only at the first clock of a frame, so a mid-frame write cannot tear a frame apart.

A power-save input freezes the whole unit: the counter, the frame position, the shadows and every output hold their state until the input is released. Register decoding and pad drivers sit outside this block.

Top module: `mpwm_unit`

## Requirements
- R1: While reset is held, every output is low. The base counter and the frame position restart so that the first clock after reset opens period 0 of frame 0.
- R2: An enabled coarse channel with compare value C (1 to 255) is high for counts 0 to C-1 of each 256-clock period, which is C clocks per period. It rises only on the clock that follows a counter wrap.
- R3: A coarse channel whose compare value is 0 never goes high.
- R4: Clearing a channel's enable drives its output low on the next clock. Setting the enable again has no effect until the next counter wrap.
- R5: For a fine channel with compare word W, let hi = W[13:6] and lo = W[5:0]. Period k of a frame (k from 0 to 63) is high for hi+1 clocks when the 6-bit bit reversal of k is less than lo, and for hi clocks otherwise. When hi = 255 and the period is stretched, the output stays high for the whole period.
- R6: Over one 64-period frame, a fine channel is high for exactly 64*hi + lo clocks.
- R7: A fine compare word that is written part-way through a frame does not change that frame. It governs the following frame.
- R8: While power-save is high, all outputs, the counter and the frame position hold their state. After release, the period resumes from the point where it stopped, so the duty counted over non-frozen clocks is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psave_i | input | 1 | Power-save freeze |
| pwm_en_i | input | 8 | Per-output enable; bits 0-5 coarse, 6-7 fine |
| cmp8_i | input | 48 | Coarse compare values, channel i at bits [8i+7:8i] |
| cmp14_i | input | 28 | Fine compare words, channel j at bits [14j+13:14j] |
| pwm_o | output | 8 | PWM outputs; bits 0-5 coarse, 6-7 fine |

## Verification
Every output is a register. A change to a compare value or an enable therefore becomes visible on the clock after the edge that samples it. A period's state at count p appears at the output p+1 edges after that period's wrap edge. The bench keeps its own count of unfrozen edges since reset, and from that count it derives the phase and the frame index of every negative-edge sample. Duty is measured as the number of high samples taken over whole periods or whole frames, starting at phase 0. Stimulus is always applied at a negative edge, so it is sampled at the next rising edge, one clock ahead of any wrap that must see it.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int BASE_W  = 8;
    localparam int EXT_W   = 6;
    localparam int CMP14_W = BASE_W + EXT_W;
    localparam logic [BASE_W-1:0] CNT_MAX   = '1;
    localparam logic [EXT_W-1:0]  FRAME_MAX = '1;

    // Timing information shared by every channel for the coming edge.
    typedef struct packed {
        logic              run;        // not frozen
        logic              wrap;       // counter is at its last count
        logic              frame_wrap; // last count of the last period in a frame
        logic [BASE_W-1:0] cnt_nxt;
        logic [EXT_W-1:0]  frame;
        logic [EXT_W-1:0]  frame_nxt;
    } tick_t;

    function automatic logic [EXT_W-1:0] bit_reverse(input logic [EXT_W-1:0] v);
        logic [EXT_W-1:0] r;
        for (int k = 0; k < EXT_W; k++) r[k] = v[EXT_W-1-k];
        return r;
    endfunction

    // High-time of one base period for a fine channel (may reach 256).
    function automatic logic [BASE_W:0] fine_threshold(input logic [CMP14_W-1:0] w,
                                                       input logic [EXT_W-1:0]   fr);
        logic [BASE_W:0] base;
        logic            extra;
        base  = {1'b0, w[CMP14_W-1:EXT_W]};
        extra = (bit_reverse(fr) < w[EXT_W-1:0]);
        return base + {{BASE_W{1'b0}}, extra};
    endfunction

endpackage

// File: rtl/mpwm_base.sv
module mpwm_base
    import mpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  psave_i,
    output tick_t tick_o
);
    logic [BASE_W-1:0] cnt_q;
    logic [EXT_W-1:0]  frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_MAX;
            frame_q <= FRAME_MAX;
        end else if (!psave_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX) frame_q <= frame_q + 1'b1;
        end
    end

    always_comb begin
        tick_o.run        = !psave_i;
        tick_o.wrap       = (cnt_q == CNT_MAX);
        tick_o.frame_wrap = (cnt_q == CNT_MAX) && (frame_q == FRAME_MAX);
        tick_o.cnt_nxt    = cnt_q + 1'b1;
        tick_o.frame      = frame_q;
        tick_o.frame_nxt  = frame_q + 1'b1;
    end
endmodule

// File: rtl/mpwm_ch8.sv
module mpwm_ch8
    import mpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tick_t             tick,
    input  logic              en_i,
    input  logic [BASE_W-1:0] cmp_i,
    output logic              pwm_o
);
    logic out_q;

    always_ff @(posedge clk) begin
        if (rst)                        out_q <= 1'b0;
        else if (tick.run) begin
            if (!en_i)                  out_q <= 1'b0;
            else if (tick.wrap)         out_q <= (cmp_i != '0);
            else if (tick.cnt_nxt == cmp_i) out_q <= 1'b0;
        end
    end

    assign pwm_o = out_q;
endmodule

// File: rtl/mpwm_ch14.sv
module mpwm_ch14
    import mpwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  tick_t              tick,
    input  logic               en_i,
    input  logic [CMP14_W-1:0] cmp_i,
    output logic               pwm_o
);
    logic [CMP14_W-1:0] shadow_q;
    logic [CMP14_W-1:0] shadow_eff;
    logic [BASE_W:0]    thr_now;
    logic [BASE_W:0]    thr_next_period;
    logic               out_q;

    always_comb begin
        shadow_eff      = (tick.run && tick.frame_wrap) ? cmp_i : shadow_q;
        thr_now         = fine_threshold(shadow_q, tick.frame);
        thr_next_period = fine_threshold(shadow_eff, tick.frame_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (tick.run && tick.frame_wrap) begin
            shadow_q <= cmp_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        out_q <= 1'b0;
        else if (tick.run) begin
            if (!en_i)                  out_q <= 1'b0;
            else if (tick.wrap)         out_q <= (thr_next_period != '0);
            else if ({1'b0, tick.cnt_nxt} == thr_now) out_q <= 1'b0;
        end
    end

    assign pwm_o = out_q;
endmodule

// File: rtl/mpwm_unit.sv
module mpwm_unit
    import mpwm_pkg::*;
#(
    parameter int N8  = 6,
    parameter int N14 = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     psave_i,
    input  logic [N8+N14-1:0]        pwm_en_i,
    input  logic [N8*BASE_W-1:0]     cmp8_i,
    input  logic [N14*CMP14_W-1:0]   cmp14_i,
    output logic [N8+N14-1:0]        pwm_o
);
    tick_t tick;
    logic  base_wrap;

    mpwm_base u_base (
        .clk     (clk),
        .rst     (rst),
        .psave_i (psave_i),
        .tick_o  (tick)
    );

    assign base_wrap = tick.wrap && tick.run;

    for (genvar i = 0; i < N8; i++) begin : g_ch8
        mpwm_ch8 u_ch (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .en_i  (pwm_en_i[i]),
            .cmp_i (cmp8_i[i*BASE_W +: BASE_W]),
            .pwm_o (pwm_o[i])
        );
    end

    for (genvar j = 0; j < N14; j++) begin : g_ch14
        mpwm_ch14 u_ch (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .en_i  (pwm_en_i[N8+j]),
            .cmp_i (cmp14_i[j*CMP14_W +: CMP14_W]),
            .pwm_o (pwm_o[N8+j])
        );
    end
endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker
    import mpwm_pkg::*;
#(
    parameter int N8  = 6,
    parameter int N14 = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   psave_i,
    input logic [N8+N14-1:0]      pwm_en_i,
    input logic [N8*BASE_W-1:0]   cmp8_i,
    input logic [N8+N14-1:0]      pwm_o,
    input logic                   base_wrap
);
    assert_reset_low_R1: assert property (@(posedge clk) rst |=> (pwm_o == '0));

    assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (rst)
        psave_i |=> $stable(pwm_o));

    assert_disable_clears_R4: assert property (@(posedge clk) disable iff (rst)
        !psave_i |=> ((pwm_o & ~$past(pwm_en_i)) == '0));

    for (genvar i = 0; i < N8 + N14; i++) begin : g_rise
        assert_rise_at_wrap_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_o[i]) |-> $past(base_wrap));
    end

    for (genvar i = 0; i < N8; i++) begin : g_zero
        assert_zero_stays_low_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_o[i]) |-> ($past(cmp8_i[i*BASE_W +: BASE_W]) != '0));
    end
endmodule

bind mpwm_unit mpwm_checker #(.N8(N8), .N14(N14)) u_mpwm_checker (
    .clk       (clk),
    .rst       (rst),
    .psave_i   (psave_i),
    .pwm_en_i  (pwm_en_i),
    .cmp8_i    (cmp8_i),
    .pwm_o     (pwm_o),
    .base_wrap (base_wrap)
);

// File: tb/mpwm_unit_bench.sv
module mpwm_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        psave;
    logic [7:0]  en;
    logic [47:0] cmp8;
    logic [27:0] cmp14;
    logic [7:0]  pwm;

    int tcount = 0;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mpwm_unit u_mpwm_unit (
        .clk      (clk),
        .rst      (rst),
        .psave_i  (psave),
        .pwm_en_i (en),
        .cmp8_i   (cmp8),
        .cmp14_i  (cmp14),
        .pwm_o    (pwm)
    );

    // Bench's own notion of time: unfrozen edges since reset.
    always @(posedge clk) begin
        if (rst) tcount <= 0;
        else if (!psave) tcount <= tcount + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rev6(input int k);
        int r = 0;
        for (int b = 0; b < 6; b++) if (k & (1 << b)) r |= 1 << (5 - b);
        return r;
    endfunction

    function automatic int cur_phase();
        return (tcount - 1) % 256;
    endfunction

    function automatic int cur_frame();
        return ((tcount - 1) / 256) % 64;
    endfunction

    task automatic wait_point(input int ph, input int fr);
        do @(negedge clk);
        while (!(tcount > 0 && cur_phase() == ph && (fr < 0 || cur_frame() == fr)));
    endtask

    task automatic measure_period(output int n [8]);
        for (int k = 0; k < 8; k++) n[k] = 0;
        repeat (256) begin
            for (int k = 0; k < 8; k++) if (pwm[k]) n[k]++;
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1; psave = 1'b0; en = 8'hFF;
        cmp8 = {6{8'd50}}; cmp14 = {2{14'h0400}};
        repeat (5) @(negedge clk);
        check(pwm == 8'h00, "R1 outputs low in reset", pwm, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tcount == 1 && cur_phase() == 0 && cur_frame() == 0, "R1 period 0 frame 0 start", pwm[0], 1);
        check(pwm[0] == 1'b1, "R1 first period opens high", pwm[0], 1);
    endtask

    task automatic test_duty8();
        int n [8];
        int v1 [6] = '{0, 1, 128, 255, 200, 37};
        int v2 [6] = '{3, 0, 254, 64, 1, 100};
        for (int i = 0; i < 6; i++) cmp8[i*8 +: 8] = 8'(v1[i]);
        wait_point(0, -1);
        measure_period(n);
        for (int i = 0; i < 6; i++)
            check(n[i] == v1[i], (v1[i] == 0) ? "R3 zero compare low" : "R2 coarse duty", n[i], v1[i]);
        for (int i = 0; i < 6; i++) cmp8[i*8 +: 8] = 8'(v2[i]);
        wait_point(0, -1);
        measure_period(n);
        for (int i = 0; i < 6; i++)
            check(n[i] == v2[i], (v2[i] == 0) ? "R3 zero compare low" : "R2 coarse duty", n[i], v2[i]);
    endtask

    task automatic test_enable();
        int n [8];
        int cnt;
        cmp8[2*8 +: 8] = 8'd128;
        wait_point(20, -1);
        en[2] = 1'b0;
        @(negedge clk);
        check(pwm[2] == 1'b0, "R4 disable low next clock", pwm[2], 0);
        wait_point(0, -1);
        measure_period(n);
        check(n[2] == 0, "R4 disabled period", n[2], 0);
        wait_point(10, -1);
        en[2] = 1'b1;
        cnt = 0;
        do begin
            if (pwm[2]) cnt++;
            @(negedge clk);
        end while (cur_phase() != 0);
        check(cnt == 0, "R4 enable waits for wrap", cnt, 0);
        measure_period(n);
        check(n[2] == 128, "R4 enabled after wrap", n[2], 128);
    endtask

    task automatic test_frame14();
        int n [8];
        int tot6 = 0, tot7 = 0;
        int hi6 = 3, lo6 = 21, hi7 = 255, lo7 = 63;
        cmp14 = {14'((hi7 << 6) | lo7), 14'((hi6 << 6) | lo6)};
        wait_point(0, 0);
        for (int f = 0; f < 64; f++) begin
            measure_period(n);
            check(n[6] == hi6 + ((rev6(f) < lo6) ? 1 : 0), "R5 fine period ch6", n[6],
                  hi6 + ((rev6(f) < lo6) ? 1 : 0));
            check(n[7] == hi7 + ((rev6(f) < lo7) ? 1 : 0), "R5 fine period ch7 full", n[7],
                  hi7 + ((rev6(f) < lo7) ? 1 : 0));
            tot6 += n[6];
            tot7 += n[7];
        end
        check(tot6 == 64 * hi6 + lo6, "R6 frame total ch6", tot6, 64 * hi6 + lo6);
        check(tot7 == 64 * hi7 + lo7, "R6 frame total ch7", tot7, 64 * hi7 + lo7);
    endtask

    task automatic test_shadow14();
        int n [8];
        int tot = 0;
        int wa = (10 << 6) | 5;
        int wb = (40 << 6) | 33;
        cmp14[13:0] = 14'(wa);
        wait_point(0, 0);
        for (int f = 0; f < 64; f++) begin
            if (f == 10) cmp14[13:0] = 14'(wb);
            measure_period(n);
            tot += n[6];
        end
        check(tot == 64 * 10 + 5, "R7 mid-frame write ignored", tot, 64 * 10 + 5);
        tot = 0;
        for (int f = 0; f < 64; f++) begin
            measure_period(n);
            tot += n[6];
        end
        check(tot == 64 * 40 + 33, "R7 new word next frame", tot, 64 * 40 + 33);
    endtask

    task automatic test_psave();
        int cnt = 0;
        logic [7:0] snap;
        bit stable_ok = 1'b1;
        cmp8[1*8 +: 8] = 8'd100;
        wait_point(0, -1);
        repeat (50) begin
            if (pwm[1]) cnt++;
            @(negedge clk);
        end
        psave = 1'b1;
        snap  = pwm;
        repeat (40) begin
            @(negedge clk);
            if (pwm !== snap) stable_ok = 1'b0;
        end
        check(stable_ok, "R8 outputs frozen", pwm, snap);
        check(cur_phase() == 50, "R8 position frozen", cur_phase(), 50);
        psave = 1'b0;
        repeat (206) begin
            if (pwm[1]) cnt++;
            @(negedge clk);
        end
        check(cnt == 100, "R8 duty resumes", cnt, 100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", tcount, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_duty8();
        test_enable();
        test_frame14();
        test_shadow14();
        test_psave();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule